// File: doc/BRIEF.md
# Grouped Change-of-State Input Interrupt Unit

This block samples 48 read-only digital input lines, arranged as two 24-bit ports. It watches them for transitions in groups of eight lines and raises one shared interrupt when a group that software has enabled sees any change. A small register bus gives software access to the six input bytes and to one interrupt register. The bus is an 8-bit data path with a 3-bit address and separate read and write strobes. Writing the interrupt register sets the per-group enable mask. Reading it returns the per-group change flags together with an active-low pending bit, and the read itself acknowledges the interrupt.

Every input line passes through a synchroniser before any use. A change is found by comparing each synchronised sample with the sample from the cycle before, so rising and falling edges count alike. Each group keeps a sticky flag that holds until the status read.

The bus and the interrupt pin are plain control signals with no valid/ready handshake and no back-pressure. A strobe is taken in the cycle it is high. Read data is combinational from the address, and the side effect of a status read takes place at the clock edge that ends the strobe.

Top module: `cos_input_irq`

## Requirements
- R1: After reset the enable mask and all group flags are zero, `irq_o` is low, and a read of offset 7 returns 0x40.
- R2: Offsets 0, 1 and 2 return input lines 7:0, 15:8 and 23:16. Offsets 4, 5 and 6 return lines 31:24, 39:32 and 47:40. A level change on an input appears in these reads two clock edges after it is first sampled, and not after one edge.
- R3: A read of offset 3 returns 0x00, and bit 7 of an offset-7 read is always 0.
- R4: A write to offset 7 loads `wdata[5:0]` as the enable mask, with bit n enabling group n (lines 8n to 8n+7). Writes to any other offset change nothing.
- R5: A rising or a falling transition on any line of an enabled group sets that group's flag and drives `irq_o` high.
- R6: Transitions in a group whose enable bit is 0 set no flag and do not raise `irq_o`.
- R7: An offset-7 read returns the group flags in bits 5:0. Bit 6 is 0 while `irq_o` is high and 1 while it is low.
- R8: A read of offset 7 clears every flag, and `irq_o` falls at that edge unless a new change is being latched.
- R9: A change that is latched at the same edge as a status read is not lost. It is absent from that read and present in the next one.
- R10: A write to offset 7 clears the flags of groups it disables, so writing 0 drops `irq_o`.
- R11: Once raised, `irq_o` stays high until a status read or a disabling write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 48 | Raw input lines, port 0 in bits 23:0, port 1 in bits 47:24 |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe; a read of offset 7 clears the status |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_o | output | 1 | Shared change-of-state interrupt, active high |

## Verification
The bench builds the block with its default parameters: three bytes per port, which gives six groups, and a two-stage synchroniser. With these values the full 8-byte register map can be reached, including the gap at offset 3 and the pending bit at position 6. The two-edge latency of the synchroniser can also be observed at the ports. Random flips across several bytes exercise combinations of enabled and disabled groups. Directed cases line up a change pulse with the edge of a status read, and write to offsets that must have no effect.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int BUS_W   = 8;
  localparam int GROUP_W = 8;

  function automatic int map_addr_w(input int port_bytes);
    return $clog2(2 * port_bytes + 2);
  endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] samp,
  output logic [W-1:0] chg
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= raw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];

  assign samp = stage_q[STAGES-1];
  assign chg  = stage_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/cos_flag_bank.sv
module cos_flag_bank #(
  parameter int NUM_GROUPS = 6,
  parameter int GROUP_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_GROUPS*GROUP_W-1:0] line_chg,
  input  logic                          ack,
  input  logic                          load_en,
  input  logic [NUM_GROUPS-1:0]         new_en,
  output logic [NUM_GROUPS-1:0]         grp_chg,
  output logic [NUM_GROUPS-1:0]         en_q,
  output logic [NUM_GROUPS-1:0]         flags_q,
  output logic                          irq
);
  logic [NUM_GROUPS-1:0] en_d, flags_d, keep;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_chg[g] = |line_chg[g*GROUP_W +: GROUP_W];
    end
  endgenerate

  always_comb begin
    keep    = ack ? '0 : flags_q;
    en_d    = load_en ? new_en : en_q;
    flags_d = (keep | (grp_chg & en_q)) & en_d;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q    <= '0;
      flags_q <= '0;
    end else begin
      en_q    <= en_d;
      flags_q <= flags_d;
    end

  assign irq = |flags_q;
endmodule

// File: rtl/cos_reg_read.sv
module cos_reg_read #(
  parameter int PORT_BYTES = 3,
  parameter int ADDR_W     = 3,
  parameter int BUS_W      = 8
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [2*PORT_BYTES*BUS_W-1:0] samp,
  input  logic [2*PORT_BYTES-1:0]       flags,
  input  logic                          irq,
  output logic [BUS_W-1:0]              rdata
);
  localparam int NG      = 2 * PORT_BYTES;
  localparam int OFF_GAP = PORT_BYTES;
  localparam int OFF_IRQ = 2 * PORT_BYTES + 1;

  logic [BUS_W-1:0] bytes [OFF_IRQ+1];

  genvar b;
  generate
    for (b = 0; b < PORT_BYTES; b++) begin : g_byte
      assign bytes[b]              = samp[b*BUS_W +: BUS_W];
      assign bytes[OFF_GAP+1+b]    = samp[(PORT_BYTES+b)*BUS_W +: BUS_W];
    end
  endgenerate

  assign bytes[OFF_GAP] = '0;

  always_comb begin
    bytes[OFF_IRQ]     = '0;
    bytes[OFF_IRQ][NG-1:0] = flags;
    bytes[OFF_IRQ][NG] = ~irq;
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) <= OFF_IRQ) rdata = bytes[addr];
  end
endmodule

// File: rtl/cos_input_irq.sv
module cos_input_irq
  import cos_pkg::*;
#(
  parameter int PORT_BYTES  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = cos_pkg::map_addr_w(PORT_BYTES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2*PORT_BYTES*8-1:0]     din,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          rd_en,
  input  logic                          wr_en,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    rdata,
  output logic                          irq_o
);
  localparam int NUM_GROUPS = 2 * PORT_BYTES;
  localparam int LINES      = NUM_GROUPS * GROUP_W;
  localparam logic [ADDR_W-1:0] OFF_IRQ = ADDR_W'(2 * PORT_BYTES + 1);

  logic [LINES-1:0]      samp, line_chg;
  logic [NUM_GROUPS-1:0] grp_chg, en_q, flags_q;
  logic                  ack, load_en;

  assign ack     = rd_en && (addr == OFF_IRQ);
  assign load_en = wr_en && (addr == OFF_IRQ);

  cos_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(din), .samp(samp), .chg(line_chg)
  );

  cos_flag_bank #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .line_chg(line_chg), .ack(ack),
    .load_en(load_en), .new_en(wdata[NUM_GROUPS-1:0]), .grp_chg(grp_chg),
    .en_q(en_q), .flags_q(flags_q), .irq(irq_o)
  );

  cos_reg_read #(.PORT_BYTES(PORT_BYTES), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_read (
    .addr(addr), .samp(samp), .flags(flags_q), .irq(irq_o), .rdata(rdata)
  );
endmodule

// File: rtl/cos_input_irq_chk.sv
module cos_input_irq_chk #(
  parameter int NUM_GROUPS = 6,
  parameter int ADDR_W     = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     addr,
  input logic                  rd_en,
  input logic                  wr_en,
  input logic [7:0]            wdata,
  input logic [7:0]            rdata,
  input logic                  irq_o,
  input logic [NUM_GROUPS-1:0] grp_chg,
  input logic [NUM_GROUPS-1:0] en_q
);
  localparam logic [ADDR_W-1:0] OFF_IRQ = ADDR_W'(NUM_GROUPS + 1);
  localparam logic [ADDR_W-1:0] OFF_GAP = ADDR_W'(NUM_GROUPS / 2);

  logic rd7, wr7;
  assign rd7 = rd_en && addr == OFF_IRQ;
  assign wr7 = wr_en && addr == OFF_IRQ;

  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_GAP) |-> rdata == 8'h00); // R3
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd7 |-> !rdata[7]); // R3
  AST_PENDING_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd7 |-> rdata[NUM_GROUPS] == !irq_o); // R7
  AST_CHANGE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(grp_chg & en_q)) && !wr_en) |=> irq_o); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd7 && grp_chg == '0) |=> !irq_o); // R8
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rd7 && !wr7) |=> irq_o); // R11
  AST_DISABLE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr7 && wdata[NUM_GROUPS-1:0] == '0) |=> !irq_o); // R10
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && !irq_o && !wr_en) |=> !irq_o); // R6
endmodule

bind cos_input_irq cos_input_irq_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .grp_chg(grp_chg), .en_q(en_q)
);

// File: tb/cos_input_irq_bench.sv
`timescale 1ns/1ps
module cos_input_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] din = '0;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq_o;

  int tests = 0, fails = 0;
  logic done = 1'b0;
  logic [5:0]  m_en = '0, m_flags = '0;
  logic [47:0] m_din = '0;

  always #2.5 clk = ~clk;

  cos_input_irq u_cos_input_irq (
    .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_status(input logic [5:0] f);
    return {1'b0, ~|f, f};
  endfunction

  function automatic logic [7:0] exp_port(input logic [47:0] v, input int a);
    if (a < 3) return v[a*8 +: 8];
    if (a == 3) return 8'h00;
    return v[(a-1)*8 +: 8];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 3'(a); rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 3'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 7) begin
      m_en = d[5:0];
      m_flags &= m_en;
    end
  endtask

  task automatic drive(input logic [47:0] v);
    @(negedge clk);
    for (int g = 0; g < 6; g++)
      if (v[g*8 +: 8] != m_din[g*8 +: 8] && m_en[g]) m_flags[g] = 1'b1;
    m_din = v; din = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_status(input string req);
    logic [7:0] d;
    bus_read(7, d);
    check(req, d, exp_status(m_flags));
    m_flags = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    bus_read(7, d); check("R1 status", d, 8'h40);

    // R2 port mapping and two-edge latency
    @(negedge clk);
    din = 48'hA5_5A_C3_3C_0F_F0; m_din = din;
    @(negedge clk); addr = 3'd0; #1 check("R2 one edge old", rdata, 8'h00);
    @(negedge clk); #1 check("R2 two edges new", rdata, 8'hF0);
    for (int a = 0; a < 7; a++) begin
      bus_read(a, d); check("R2 byte map", d, exp_port(m_din, a));
    end
    // R3 gap reads zero
    bus_read(3, d); check("R3 gap", d, 8'h00);

    // R6 disabled groups do not flag
    drive(~m_din);
    check("R6 irq", {7'd0, irq_o}, 8'h00);
    read_status("R6 status");

    // R4 writes elsewhere ignored
    bus_write(2, 8'h3F); bus_write(3, 8'h3F);
    drive(m_din ^ 48'h0101_0101_0101);
    check("R4 stray write irq", {7'd0, irq_o}, 8'h00);

    // R5 both edges, R11 holds, R7 and R8
    bus_write(7, 8'h05);
    drive(m_din ^ 48'h0000_0001_0000);
    check("R5 rising/falling irq", {7'd0, irq_o}, 8'h01);
    repeat (5) @(negedge clk);
    check("R11 hold", {7'd0, irq_o}, 8'h01);
    read_status("R7 status");
    check("R8 cleared", {7'd0, irq_o}, 8'h00);
    drive(m_din ^ 48'h0000_0001_0000);
    read_status("R5 reverse edge");

    // R10 disabling write clears
    drive(m_din ^ 48'h0000_0080_0080);
    check("R10 pre", {7'd0, irq_o}, 8'h01);
    bus_write(7, 8'h00);
    check("R10 irq", {7'd0, irq_o}, 8'h00);
    read_status("R10 status");

    // R9 change coinciding with status read
    bus_write(7, 8'h3F);
    @(negedge clk);
    m_din = m_din ^ 48'h0000_0004_0000; din = m_din;
    @(negedge clk);
    @(negedge clk);
    addr = 3'd7; rd_en = 1'b1;
    #1 check("R9 same-edge read", rdata, 8'h40);
    @(negedge clk); rd_en = 1'b0;
    #1 check("R9 irq kept", {7'd0, irq_o}, 8'h01);
    m_flags = 6'h04;
    read_status("R9 next read");

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [47:0] flip;
      if ($urandom_range(0, 2) == 0) bus_write(7, 8'($urandom));
      flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      drive(m_din ^ flip);
      check("R5/R6 random irq", {7'd0, irq_o}, {7'd0, |m_flags});
      begin
        int a = $urandom_range(0, 6);
        bus_read(a, d); check("R2 random byte", d, exp_port(m_din, a));
      end
      if ($urandom_range(0, 1) == 0) read_status("R7/R8 random status");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule